// File: doc/BRIEF.md
# Read-Kicked Watchdog Pulse Generator

This block is a free-running watchdog timer that runs on a crystal clock. The crystal clock has no fixed phase relation to the CPU bus clock. Software keeps the watchdog quiet by reading one designated register offset on the bus. Each such read is turned into a toggle in the bus domain. The toggle is carried into the crystal domain through a two-flop synchroniser, and an edge detector there turns it into a one-cycle kick that clears the timeout counter.

If no kick arrives for 2^TIMEOUT_LOG2 crystal cycles, the output goes high for exactly 2^PULSE_LOG2 crystal cycles. The defaults are 2^28 and 2^8 cycles, which at 21.47727 MHz give about 12.49 s and 11.9 µs. The counter keeps running through the pulse. While no kick arrives, a new pulse therefore starts every 2^TIMEOUT_LOG2 cycles after the start of the previous one. All pulse timing comes from the crystal clock alone.

The timing unit is a two-state machine:
- `ST_COUNT` is entered from reset and on every kick. In this state the output is low.
- `ST_COUNT` moves to `ST_PULSE` when the counter reaches its all-ones value (transition T_EXPIRE).
- `ST_PULSE` holds the output high. It returns to `ST_COUNT` when the counter reaches 2^PULSE_LOG2-1 (transition T_PULSE_DONE).
- A kick in either state forces `ST_COUNT` and clears the counter (transition T_KICK).

Top module: `rd_kick_watchdog`

## Requirements
- R1: While rst_n is low, pulse_out is low. After release, the first pulse_out rise is seen after exactly 2^TIMEOUT_LOG2 rising edges of xtal_clk.
- R2: Without a kick, every pulse lasts exactly 2^PULSE_LOG2 xtal_clk cycles.
- R3: Without a kick, pulses repeat with a period of 2^TIMEOUT_LOG2 xtal_clk cycles, measured from rise to rise.
- R4: A bus read (bus_rd high on a bus_clk rising edge) with bus_addr equal to KICK_ADDR (default 4'hC) restarts the timeout. The next pulse rises between 2^TIMEOUT_LOG2 and 2^TIMEOUT_LOG2+8 xtal_clk cycles after the read.
- R5: A bus read at any address other than KICK_ADDR has no effect on the timing of pulse_out.
- R6: A kick that arrives while pulse_out is high ends the pulse within 8 xtal_clk cycles of the read, and the count restarts from zero.
- R7: A kick is delivered to the crystal domain as a single-cycle event, one per qualifying read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | CPU bus clock |
| xtal_clk | input | 1 | Crystal clock that times the watchdog |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| bus_rd | input | 1 | Read strobe, sampled on bus_clk |
| bus_addr | input | ADDR_W | Register offset of the bus access |
| pulse_out | output | 1 | Watchdog pulse, high while a timeout pulse is in progress |

## Verification
The timeout is shortened to 2^10 cycles and the pulse to 2^4 cycles. The bench measures pulse_out over fixed windows in four situations:
- Back-to-back kicks, where no pulse may appear.
- A single kick followed by silence, which shows the kick-to-pulse delay.
- A read at a non-kick offset, which must leave an earlier pulse schedule untouched.
- A long silence, which must give several evenly spaced pulses of full width.

Directed runs add two cases. One counts exact cycles from reset release, which separates an off-by-one in the counter from the synchroniser delay. The other places a kick inside a pulse, which shows whether a kick can cut a pulse short.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    typedef enum logic [0:0] {
        ST_COUNT = 1'b0,
        ST_PULSE = 1'b1
    } wdg_state_t;
endpackage

// File: rtl/wdg_kick_src.sv
module wdg_kick_src #(
    parameter int              ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] KICK_ADDR = 4'hC
) (
    input  logic              bus_clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              kick_tog
);
    logic hit;

    always_comb hit = bus_rd && (bus_addr == KICK_ADDR);

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) kick_tog <= 1'b0;
        else if (hit) kick_tog <= ~kick_tog;
    end

    // R5: reads at other offsets leave the toggle untouched
    a_r5_other_addr_ignored: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (bus_rd && bus_addr != KICK_ADDR) |=> $stable(kick_tog));
endmodule

// File: rtl/wdg_kick_sync.sv
module wdg_kick_sync (
    input  logic xtal_clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic kick
);
    logic meta_q, sync_q, last_q;

    always_ff @(posedge xtal_clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= tog_in;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    always_comb kick = sync_q ^ last_q;

    // R7: a kick lasts one crystal cycle
    a_r7_kick_single: assert property (@(posedge xtal_clk) disable iff (!rst_n)
        kick |=> !kick);
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
    import wdg_pkg::*;
#(
    parameter int TIMEOUT_LOG2 = 28,
    parameter int PULSE_LOG2   = 8
) (
    input  logic xtal_clk,
    input  logic rst_n,
    input  logic kick,
    output logic pulse_out
);
    localparam int                CW         = TIMEOUT_LOG2;
    localparam logic [CW-1:0]     CNT_LAST   = '1;
    localparam logic [CW-1:0]     PULSE_LAST = {{(CW-PULSE_LOG2){1'b0}}, {PULSE_LOG2{1'b1}}};
    localparam int                RUN_W      = PULSE_LOG2 + 2;
    localparam logic [RUN_W-1:0]  PULSE_LEN  = RUN_W'(1) << PULSE_LOG2;

    wdg_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + CW'(1);
        if (kick) begin
            state_d = ST_COUNT;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_COUNT: if (cnt_q == CNT_LAST)   state_d = ST_PULSE;
                ST_PULSE: if (cnt_q == PULSE_LAST) state_d = ST_COUNT;
            endcase
        end
    end

    always_ff @(posedge xtal_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COUNT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb pulse_out = (state_q == ST_PULSE);

    logic [RUN_W-1:0] hi_run_q;
    always_ff @(posedge xtal_clk or negedge rst_n) begin
        if (!rst_n)         hi_run_q <= '0;
        else if (pulse_out) hi_run_q <= hi_run_q + RUN_W'(1);
        else                hi_run_q <= '0;
    end

    // R2: a pulse never exceeds its nominal width
    a_r2_pulse_width: assert property (@(posedge xtal_clk) disable iff (!rst_n)
        hi_run_q <= PULSE_LEN);
    // R3: expiry of the count starts a pulse
    a_r3_expire_to_pulse: assert property (@(posedge xtal_clk) disable iff (!rst_n)
        (!pulse_out && !kick && cnt_q == CNT_LAST) |=> pulse_out);
    // R4: a kick clears the counter
    a_r4_kick_clears: assert property (@(posedge xtal_clk) disable iff (!rst_n)
        kick |=> (cnt_q == '0));
    // R6: a kick during a pulse ends it
    a_r6_kick_ends_pulse: assert property (@(posedge xtal_clk) disable iff (!rst_n)
        (pulse_out && kick) |=> !pulse_out);
endmodule

// File: rtl/rd_kick_watchdog.sv
module rd_kick_watchdog #(
    parameter int                ADDR_W       = 4,
    parameter logic [ADDR_W-1:0] KICK_ADDR    = 4'hC,
    parameter int                TIMEOUT_LOG2 = 28,
    parameter int                PULSE_LOG2   = 8
) (
    input  logic              bus_clk,
    input  logic              xtal_clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              pulse_out
);
    logic kick_tog;
    logic kick;

    wdg_kick_src #(.ADDR_W(ADDR_W), .KICK_ADDR(KICK_ADDR)) u_src (
        .bus_clk  (bus_clk),
        .rst_n    (rst_n),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .kick_tog (kick_tog)
    );

    wdg_kick_sync u_sync (
        .xtal_clk (xtal_clk),
        .rst_n    (rst_n),
        .tog_in   (kick_tog),
        .kick     (kick)
    );

    wdg_timer #(.TIMEOUT_LOG2(TIMEOUT_LOG2), .PULSE_LOG2(PULSE_LOG2)) u_timer (
        .xtal_clk  (xtal_clk),
        .rst_n     (rst_n),
        .kick      (kick),
        .pulse_out (pulse_out)
    );

    // R1: output low during reset
    always_comb begin
        if (!rst_n) a_r1_reset_low: assert (!pulse_out);
    end
endmodule

// File: tb/rd_kick_watchdog_tb.sv
module rd_kick_watchdog_tb;
    localparam int TO_LOG2 = 10;
    localparam int PW_LOG2 = 4;
    localparam int TO_LEN  = 1 << TO_LOG2;
    localparam int PW_LEN  = 1 << PW_LOG2;

    logic bus_clk = 1'b0, xtal_clk = 1'b0, rst_n = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic pulse_out;

    int checks = 0, fails = 0, cyc = 0, rises = 0, highs = 0;
    logic prev_p = 1'b0;
    bit done = 1'b0;

    always #2 xtal_clk = ~xtal_clk;
    always #7 bus_clk  = ~bus_clk;

    rd_kick_watchdog #(.TIMEOUT_LOG2(TO_LOG2), .PULSE_LOG2(PW_LOG2)) u_dut (
        .bus_clk(bus_clk), .xtal_clk(xtal_clk), .rst_n(rst_n),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .pulse_out(pulse_out)
    );

    always @(negedge xtal_clk) begin
        cyc <= cyc + 1;
        if (pulse_out && !prev_p) rises <= rises + 1;
        if (pulse_out) highs <= highs + 1;
        prev_p <= pulse_out;
    end

    // {addr[31:28], rises[27:24], highs[23:16], window[15:0]}
    localparam int NV = 5;
    localparam logic [31:0] VEC [NV] = '{
        {4'hC, 4'd0, 8'd0,  16'd900},   // R4 kick, quiet window
        {4'hC, 4'd1, 8'd16, 16'd1124},  // R4 kick then one pulse
        {4'h3, 4'd1, 8'd16, 16'd1000},  // R5 other offset: schedule kept
        {4'hC, 4'd3, 8'd48, 16'd3200},  // R3 repeat, R2 width
        {4'hC, 4'd0, 8'd0,  16'd500}    // R4 kick again
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [3:0] a);
        @(negedge bus_clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge bus_clk);
        bus_rd = 1'b0; bus_addr = 4'h0;
    endtask

    task automatic wait_x(input int n);
        repeat (n) @(negedge xtal_clk);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        wait_x(150000);
        check(1'b0, "watchdog", 0, 1);
        finish_up();
    end

    initial begin
        int hi_cnt;
        wait_x(3);
        check(pulse_out == 1'b0, "R1 reset low", pulse_out, 0);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NV; i++) begin
            int r0, h0, er, eh;
            r0 = rises; h0 = highs;
            bus_read(VEC[i][31:28]);
            wait_x(int'(VEC[i][15:0]));
            er = int'(VEC[i][27:24]); eh = int'(VEC[i][23:16]);
            check(rises - r0 == er, $sformatf("R4/R5/R3 vec%0d rises", i), rises - r0, er);
            check(highs - h0 == eh, $sformatf("R2 vec%0d highs", i), highs - h0, eh);
        end

        // R1 exact timing from reset release
        @(negedge xtal_clk);
        rst_n = 1'b0;
        #1;
        check(pulse_out == 1'b0, "R1 low in reset", pulse_out, 0);
        wait_x(2);
        rst_n = 1'b1;
        wait_x(TO_LEN - 1);
        check(pulse_out == 1'b0, "R1 low before timeout", pulse_out, 0);
        wait_x(1);
        check(pulse_out == 1'b1, "R1 high at timeout", pulse_out, 1);
        wait_x(PW_LEN - 1);
        check(pulse_out == 1'b1, "R2 high at last cycle", pulse_out, 1);
        wait_x(1);
        check(pulse_out == 1'b0, "R2 low after width", pulse_out, 0);
        wait_x(TO_LEN - PW_LEN - 1);
        check(pulse_out == 1'b0, "R3 low before repeat", pulse_out, 0);
        wait_x(1);
        check(pulse_out == 1'b1, "R3 repeat rise", pulse_out, 1);

        // R6 kick during pulse (pulse began 1 cycle ago)
        hi_cnt = highs;
        wait_x(3);
        bus_read(4'hC);
        wait_x(8);
        check(pulse_out == 1'b0, "R6 pulse cut", pulse_out, 0);
        check(highs - hi_cnt < PW_LEN, "R6 shortened", highs - hi_cnt, PW_LEN - 1);
        begin
            int r0;
            r0 = rises;
            wait_x(TO_LEN - 40);
            check(rises == r0, "R6 count restarted", rises - r0, 0);
            wait_x(60);
            check(rises - r0 == 1, "R4 pulse after restart", rises - r0, 1);
        end
        finish_up();
    end
endmodule